// File: doc/BRIEF.md
# Oscillation Stabilization Timer

This block measures how long the high-speed oscillator has been running since it was last started. Every cycle in which the oscillator tick-enable is high advances an internal counter. Five power-of-two thresholds are compared against that count, and the results are exposed as a thermometer-coded status word. Software can poll this word after reset release to decide when the fast clock may be trusted.

When the block is woken from a low-power stop, a 3-bit select input picks one of the five wait times. A registered done output rises once that wait is over. The done output gates the switch of the clock source. A restart pulse marks each new oscillator start. Reset marks the start after power-up, because the oscillator is halted while reset is held.

The thresholds are 2^(B), 2^(B+2), 2^(B+3), 2^(B+4) and 2^(B+5) ticks, where B is the parameter `EXP_BASE`. With the default B = 11 this gives 2^11, 2^13, 2^14, 2^15 and 2^16.

Top module: `osc_stab_timer`

## Requirements
- R1: While `rst` is high the count, `status` and `done` are all zero and ticks are not counted. After release, `status` and `done` read zero until ticks arrive.
- R2: The count advances by one only on clock edges where `tick_en` is high and `restart` is low. Cycles with `tick_en` low leave every output unchanged.
- R3: `status` bit k is 1 exactly when the count is at least threshold T_k, with T_0 = 2^B and T_k = 2^(B+k+1) for k = 1..4. Bit 0 therefore holds the shortest wait, and the status bits update on the same edge as the count.
- R4: `status` does not depend on `sel`. It reads the same for any select value, so software can poll it after reset without choosing a wait.
- R5: Select codes 0, 1, 2, 3 and 4 choose T_0, T_1, T_2, T_3 and T_4 respectively. `done` becomes 1 on the edge where the selected `status` bit becomes 1.
- R6: Select codes 5, 6 and 7 behave exactly as code 4 (the longest wait).
- R7: Once `done` is 1 it stays 1 until a restart or reset, even if `sel` later names a longer wait.
- R8: The count saturates at T_4. Further ticks keep `status` all ones and `done` unchanged.
- R9: A `restart` pulse clears the count, `status` and `done` on its edge, even while counting and even if `tick_en` is high in the same cycle. Counting resumes from zero on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; oscillator considered stopped |
| tick_en | input | 1 | High for one cycle per high-speed oscillator tick |
| restart | input | 1 | Oscillator (re)start pulse; clears count, status and done |
| sel | input | 3 | Wait-time select code for the done output |
| status | output | 5 | Thermometer of thresholds passed, bit 0 shortest |
| done | output | 1 | Selected wait has elapsed since the last start |

## Verification
The assertions assume that `rst` is sampled synchronously. They also assume that `restart` and `tick_en` may be high together, in which case the restart wins, and that `sel` may change on any cycle, including after `done` has risen. The bench drives every input just after the falling clock edge and reads the outputs at the next falling edge, so every change is seen on exactly one rising edge. The bench runs a small configuration with B = 3, so each select code can be swept past saturation. It uses both continuous and gapped tick patterns, and it exercises restarts and resets both mid-count and with a tick in the same cycle.

// File: rtl/osc_stab_pkg.sv
package osc_stab_pkg;
  localparam int NUM_THR = 5;
  localparam int SEL_W   = 3;
  localparam int IDX_W   = 3;

  // exponent step of threshold k above the base exponent
  function automatic int exp_offset(input int k);
    return (k == 0) ? 0 : k + 1;
  endfunction

  // map a select code onto a threshold index, clamping large codes
  function automatic logic [IDX_W-1:0] sel_to_idx(input logic [SEL_W-1:0] s);
    return (s > SEL_W'(NUM_THR - 1)) ? IDX_W'(NUM_THR - 1) : IDX_W'(s);
  endfunction
endpackage

// File: rtl/osc_stab_counter.sv
module osc_stab_counter #(
  parameter int EXP_BASE = 11,
  localparam int CNT_W   = EXP_BASE + 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             restart,
  output logic [CNT_W-1:0] count_d
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(1) << (EXP_BASE + 5);

  logic [CNT_W-1:0] count_q;

  always_comb begin
    count_d = count_q;
    if (restart)
      count_d = '0;
    else if (tick_en && (count_q != MAX_CNT))
      count_d = count_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_d;
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !restart && count_q != MAX_CNT) |=> count_q == $past(count_q) + CNT_W'(1));
  assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !restart) |=> $stable(count_q));
  assert_saturate_R8: assert property (@(posedge clk) disable iff (rst)
    (count_q == MAX_CNT && !restart) |=> count_q == MAX_CNT);
  assert_restart_clear_R9: assert property (@(posedge clk) disable iff (rst)
    restart |=> count_q == '0);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> count_q == '0);
endmodule

// File: rtl/osc_stab_thermo.sv
module osc_stab_thermo
  import osc_stab_pkg::*;
#(
  parameter int EXP_BASE = 11,
  localparam int CNT_W   = EXP_BASE + 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic [CNT_W-1:0]   count_d,
  output logic [NUM_THR-1:0] status_d,
  output logic [NUM_THR-1:0] status_q
);
  for (genvar k = 0; k < NUM_THR; k++) begin : g_cmp
    localparam int E = EXP_BASE + exp_offset(k);
    localparam logic [CNT_W-1:0] THR = CNT_W'(1) << E;
    assign status_d[k] = (count_d >= THR);
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= status_d;
  end

  for (genvar k = 0; k < NUM_THR - 1; k++) begin : g_shape
    assert_thermo_shape_R3: assert property (@(posedge clk) disable iff (rst)
      status_q[k+1] |-> status_q[k]);
  end

  assert_monotonic_R3: assert property (@(posedge clk) disable iff (rst)
    !restart |=> (($past(status_q) & ~status_q) == '0));
  assert_restart_status_R9: assert property (@(posedge clk) disable iff (rst)
    restart |=> status_q == '0);
endmodule

// File: rtl/osc_stab_done.sv
module osc_stab_done
  import osc_stab_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic [SEL_W-1:0]   sel,
  input  logic [NUM_THR-1:0] status_d,
  input  logic [NUM_THR-1:0] status_q,
  output logic               done_q
);
  logic [IDX_W-1:0] idx;
  logic             done_d;

  assign idx    = sel_to_idx(sel);
  assign done_d = !restart && (done_q || status_d[idx]);

  always_ff @(posedge clk) begin
    if (rst) done_q <= 1'b0;
    else     done_q <= done_d;
  end

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (done_q && !restart) |=> done_q);
  assert_done_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> status_q[$past(idx)]);
  assert_done_clear_R9: assert property (@(posedge clk) disable iff (rst)
    restart |=> !done_q);
endmodule

// File: rtl/osc_stab_timer.sv
module osc_stab_timer
  import osc_stab_pkg::*;
#(
  parameter int EXP_BASE = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_en,
  input  logic               restart,
  input  logic [SEL_W-1:0]   sel,
  output logic [NUM_THR-1:0] status,
  output logic               done
);
  localparam int CNT_W = EXP_BASE + 6;

  logic [CNT_W-1:0]   count_d;
  logic [NUM_THR-1:0] status_d;
  logic [NUM_THR-1:0] status_q;
  logic               done_q;

  osc_stab_counter #(.EXP_BASE(EXP_BASE)) u_cnt (
    .clk(clk), .rst(rst), .tick_en(tick_en), .restart(restart), .count_d(count_d)
  );

  osc_stab_thermo #(.EXP_BASE(EXP_BASE)) u_thermo (
    .clk(clk), .rst(rst), .restart(restart), .count_d(count_d),
    .status_d(status_d), .status_q(status_q)
  );

  osc_stab_done u_done (
    .clk(clk), .rst(rst), .restart(restart), .sel(sel),
    .status_d(status_d), .status_q(status_q), .done_q(done_q)
  );

  assign status = status_q;
  assign done   = done_q;

  assert_reset_outputs_R1: assert property (@(posedge clk)
    rst |=> (status == '0 && !done));
endmodule

// File: tb/tb_osc_stab_timer.sv
module tb_osc_stab_timer;
  localparam int EB   = 3;
  localparam int MAXC = 1 << (EB + 5);

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       restart = 1'b0;
  logic [2:0] sel = 3'd0;
  logic [4:0] status;
  logic       done;

  int  checks = 0;
  int  fails = 0;
  int  cnt = 0;
  bit  dexp = 1'b0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  osc_stab_timer #(.EXP_BASE(EB)) dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .restart(restart),
    .sel(sel), .status(status), .done(done)
  );

  function automatic int thr(input int k);
    return 1 << (EB + ((k == 0) ? 0 : k + 1));
  endfunction

  function automatic int sidx(input logic [2:0] s);
    return (s > 3'd4) ? 4 : int'(s);
  endfunction

  function automatic logic [4:0] exp_status(input int c);
    logic [4:0] r;
    for (int k = 0; k < 5; k++) r[k] = (c >= thr(k));
    return r;
  endfunction

  task automatic chk_status(input string req);
    checks++;
    if (status !== exp_status(cnt)) begin
      fails++;
      $display("FAIL %s status actual=%b expected=%b (count %0d sel %0d)",
               req, status, exp_status(cnt), cnt, sel);
    end
  endtask

  task automatic chk_done(input string req);
    checks++;
    if (done !== dexp) begin
      fails++;
      $display("FAIL %s done actual=%b expected=%b (count %0d sel %0d)",
               req, done, dexp, cnt, sel);
    end
  endtask

  // drive for one cycle from a falling edge, update model, return at next falling edge
  task automatic cycle(input bit t, input bit r);
    tick_en = t;
    restart = r;
    @(posedge clk);
    if (rst || r) begin
      cnt  = 0;
      dexp = 1'b0;
    end else begin
      if (t && cnt < MAXC) cnt++;
      if (cnt >= thr(sidx(sel))) dexp = 1'b1;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: ticks during reset are ignored
    for (int i = 0; i < 6; i++) cycle(1'b1, 1'b0);
    chk_status("R1");
    chk_done("R1");
    rst = 1'b0;
    cycle(1'b0, 1'b0);
    chk_status("R1");
    chk_done("R1");

    // sweeps over every select code, continuous and gapped ticks
    for (int s = 0; s < 8; s++) begin
      sel = 3'(s);
      cycle(1'b0, 1'b1);
      chk_status("R9");
      chk_done("R9");
      for (int i = 0; i < MAXC + 40; i++) begin
        bit gap;
        gap = (s % 2 == 1);
        cycle(gap ? (i % 3 != 1) : 1'b1, 1'b0);
        if (cnt >= MAXC)  chk_status("R8");
        else if (gap)     chk_status("R2");
        else if (s == 7)  chk_status("R4");
        else              chk_status("R3");
        if (s > 4) chk_done("R6");
        else       chk_done("R5");
      end
    end

    // R7: done stays high after switching to a longer wait
    sel = 3'd0;
    cycle(1'b0, 1'b1);
    for (int i = 0; i < thr(0); i++) cycle(1'b1, 1'b0);
    chk_done("R5");
    sel = 3'd4;
    for (int i = 0; i < 5; i++) cycle(1'b1, 1'b0);
    chk_done("R7");
    for (int i = 0; i < 5; i++) cycle(1'b0, 1'b0);
    chk_done("R7");
    chk_status("R2");

    // R9: restart mid-count with a tick in the same cycle
    sel = 3'd1;
    cycle(1'b0, 1'b1);
    for (int i = 0; i < 40; i++) cycle(1'b1, 1'b0);
    chk_status("R3");
    chk_done("R5");
    cycle(1'b1, 1'b1);
    chk_status("R9");
    chk_done("R9");
    for (int i = 0; i < thr(0) - 1; i++) cycle(1'b1, 1'b0);
    chk_status("R9");
    cycle(1'b1, 1'b0);
    chk_status("R9");

    // R1: reset mid-count
    for (int i = 0; i < 30; i++) cycle(1'b1, 1'b0);
    rst = 1'b1;
    cycle(1'b1, 1'b0);
    cycle(1'b1, 1'b0);
    chk_status("R1");
    chk_done("R1");
    rst = 1'b0;
    for (int i = 0; i < thr(0); i++) cycle(1'b1, 1'b0);
    chk_status("R1");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule